// File: doc/BRIEF.md
# Boundary Scan Ring with Output-Bus Disable Cell

This block is the data side of a boundary scan path wrapped around a device's pin ring. It is a parameterised chain of scan cells. Each output pin, each input pin and one extra control cell has its own cell, and every cell holds a shift stage plus an update latch. The TAP controller and the instruction decoder sit outside and drive it with one-cycle capture, shift and update strobes and three instruction flags: external test, sample/preload and sample-with-high-Z.

When a capture strobe arrives, the chain takes a snapshot of the ring. Shift strobes move the chain one place from the TDI end (most significant bit) toward the TDO end (bit 0). An update strobe copies the chain into the latches, so a pattern can be preloaded before another test is chosen. Under external test the latches take over the output pins and the core-side inputs. The control cell sits at a fixed chain index, and its latched value gates the whole output bus. The high-Z flag releases the bus whatever the latches hold.

Chain layout: bit `CTL_IDX` is the control cell. Every other bit `i` maps to slot `s = i` when `i < CTL_IDX`, and to `s = i - 1` otherwise. Slots `0..N_OUT-1` are output pins. Slots `N_OUT..N_OUT+N_IN-1` are input pins `s - N_OUT`. Chain length is `N_OUT + N_IN + 1`, which is 86 with the defaults, and the control cell is at 85.

Top module: `bscan_ring`

## Requirements
- R1: A synchronous reset clears all shift stages and latches to 0, and also `pin_out` and `pin_oe`. `tdo` reads 0 after reset.
- R2: When `capture_dr` is high, the chain loads on the next edge. An output cell loads `core_out` of its slot, an input cell loads `pin_in` of its slot, and the control cell loads `core_oe`.
- R3: When `shift_dr` is high and `capture_dr` is low, each bit takes the value of the bit above it. The top bit takes `tdi`. `tdo` is always bit 0 of the chain.
- R4: On a cycle with neither `capture_dr` nor `shift_dr`, the chain holds its contents.
- R5: `update_dr` copies the chain into the latches only while `mode_extest` or `mode_sample` is high. With neither flag high it leaves the latches unchanged.
- R6: While `mode_extest` is high, `pin_out` shows the output-cell latches one cycle later.
- R7: While `mode_extest` is high and `mode_highz` is low, `pin_oe` shows the control-cell latch one cycle later. A latched 1 enables the drivers and a latched 0 releases the bus.
- R8: While `mode_highz` is high, `pin_oe` is 0 one cycle later. This holds even when `mode_extest` is also high.
- R9: With `mode_extest` and `mode_highz` both low, `pin_out` and `pin_oe` show `core_out` and `core_oe` one cycle later.
- R10: `core_in` equals `pin_in` in the same cycle, except under `mode_extest`, when it shows the input-cell latches.
- R11: When `capture_dr` and `shift_dr` are high together, the capture takes effect and the shift does not.
- R12: Under `mode_sample`, captured data shifts out while new data shifts in during a single pass. Updates load the latches, and the pins keep their functional values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and pin register clock |
| rst | input | 1 | Synchronous active-high reset |
| core_out | input | N_OUT | Functional output data from the core |
| core_oe | input | 1 | Functional output-bus enable from the core |
| pin_in | input | N_IN | Values present on the input pins |
| tdi | input | 1 | Serial data into the top of the chain |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode_extest | input | 1 | External test instruction is current |
| mode_sample | input | 1 | Sample/preload instruction is current |
| mode_highz | input | 1 | Sample-with-high-Z instruction is current |
| pin_out | output | N_OUT | Registered drive values for the output pins |
| pin_oe | output | 1 | Registered output-bus enable (1 = drive) |
| core_in | output | N_IN | Input values presented to the core |
| tdo | output | 1 | Serial data out of chain bit 0 |

## Verification
A shift stage holding the wrong bit does not show up when it goes wrong. It shows at `tdo` after as many shift strobes as the bit's distance from bit 0, which can be up to 85 cycles. A latch fault shows up only under external test. It appears on `pin_out`, `pin_oe` or `core_in` one cycle after the flag is set for the pins, or in the same cycle for `core_in`. A wrong control-cell index or a wrong slot mapping shows up as a misplaced bit once a full capture is shifted out, or once a pattern is updated and external test is applied.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    CELL_OUT = 2'd0,
    CELL_IN  = 2'd1,
    CELL_CTL = 2'd2
  } cell_kind_e;

  // Slot number of a chain bit once the control cell is skipped over.
  function automatic int chain_slot(input int idx, input int ctl_idx);
    return (idx < ctl_idx) ? idx : idx - 1;
  endfunction

  function automatic cell_kind_e kind_of(input int idx, input int ctl_idx,
                                         input int n_out);
    if (idx == ctl_idx) return CELL_CTL;
    if (chain_slot(idx, ctl_idx) < n_out) return CELL_OUT;
    return CELL_IN;
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic sh,
  input  logic upd,
  input  logic cap_val,
  input  logic ser_in,
  output logic ser_q,
  output logic lat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      if (cap)      ser_q <= cap_val;
      else if (sh)  ser_q <= ser_in;
      if (upd)      lat_q <= ser_q;
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap && !sh) |=> $stable(ser_q));

  // R3
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (sh && !cap) |=> (ser_q == $past(ser_in)));

  // R11
  cap_first_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (ser_q == $past(cap_val)));

endmodule

// File: rtl/bscan_drive.sv
module bscan_drive #(
  parameter int N_OUT = 41,
  parameter int N_IN  = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] core_out,
  input  logic             core_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] lat_out,
  input  logic [N_IN-1:0]  lat_in,
  input  logic             lat_ctl,
  input  logic             extest,
  input  logic             highz,
  output logic [N_OUT-1:0] pin_out,
  output logic             pin_oe,
  output logic [N_IN-1:0]  core_in
);

  logic [N_OUT-1:0] out_sel;
  logic             oe_sel;

  always_comb begin
    out_sel = extest ? lat_out : core_out;
    if (highz)       oe_sel = 1'b0;
    else if (extest) oe_sel = lat_ctl;
    else             oe_sel = core_oe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= out_sel;
      pin_oe  <= oe_sel;
    end
  end

  assign core_in = extest ? lat_in : pin_in;

  // R8
  highz_chk: assert property (@(posedge clk) disable iff (rst)
    highz |=> !pin_oe);

  // R7
  ctl_cell_chk: assert property (@(posedge clk) disable iff (rst)
    (extest && !highz) |=> (pin_oe == $past(lat_ctl)));

  // R9
  func_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!extest && !highz) |=> (pin_oe == $past(core_oe)));

  // R6
  extest_out_chk: assert property (@(posedge clk) disable iff (rst)
    extest |=> (pin_out == $past(lat_out)));

endmodule

// File: rtl/bscan_ring.sv
module bscan_ring
  import bscan_pkg::*;
#(
  parameter int N_OUT   = 41,
  parameter int N_IN    = 44,
  parameter int CTL_IDX = 85
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] core_out,
  input  logic             core_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             mode_extest,
  input  logic             mode_sample,
  input  logic             mode_highz,
  output logic [N_OUT-1:0] pin_out,
  output logic             pin_oe,
  output logic [N_IN-1:0]  core_in,
  output logic             tdo
);

  localparam int LEN = N_OUT + N_IN + 1;

  logic [LEN-1:0]   sh_q;
  logic [LEN-1:0]   lat_q;
  logic [LEN-1:0]   cap_v;
  logic [LEN-1:0]   ser_in_v;
  logic [N_OUT-1:0] lat_out;
  logic [N_IN-1:0]  lat_in;
  logic             lat_ctl;
  logic             upd_en;

  assign upd_en = update_dr & (mode_extest | mode_sample);

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    localparam int         SLOT = chain_slot(i, CTL_IDX);
    localparam cell_kind_e KIND = kind_of(i, CTL_IDX, N_OUT);

    if (KIND == CELL_CTL) begin : g_ctl
      assign cap_v[i] = core_oe;
      assign lat_ctl  = lat_q[i];
    end else if (KIND == CELL_OUT) begin : g_out
      assign cap_v[i]      = core_out[SLOT];
      assign lat_out[SLOT] = lat_q[i];
    end else begin : g_in
      assign cap_v[i]            = pin_in[SLOT-N_OUT];
      assign lat_in[SLOT-N_OUT]  = lat_q[i];
    end

    if (i == LEN-1) begin : g_top
      assign ser_in_v[i] = tdi;
    end else begin : g_mid
      assign ser_in_v[i] = sh_q[i+1];
    end

    bscan_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .cap     (capture_dr),
      .sh      (shift_dr),
      .upd     (upd_en),
      .cap_val (cap_v[i]),
      .ser_in  (ser_in_v[i]),
      .ser_q   (sh_q[i]),
      .lat_q   (lat_q[i])
    );
  end

  assign tdo = sh_q[0];

  bscan_drive #(
    .N_OUT (N_OUT),
    .N_IN  (N_IN)
  ) u_drive (
    .clk      (clk),
    .rst      (rst),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pin_in   (pin_in),
    .lat_out  (lat_out),
    .lat_in   (lat_in),
    .lat_ctl  (lat_ctl),
    .extest   (mode_extest),
    .highz    (mode_highz),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .core_in  (core_in)
  );

  // R5
  upd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (update_dr && !mode_extest && !mode_sample) |=> $stable(lat_q));

  // R12
  preload_chk: assert property (@(posedge clk) disable iff (rst)
    (update_dr && mode_sample) |=> (lat_q == $past(sh_q)));

  // R3
  tdo_move_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_dr && !capture_dr) |=> (tdo == $past(sh_q[1])));

endmodule

// File: tb/test_bscan_ring.sv
module test_bscan_ring;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT = 41;
  localparam int N_IN  = 44;
  localparam int CTL   = 85;
  localparam int LEN   = N_OUT + N_IN + 1;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_OUT-1:0] core_out = '0;
  logic core_oe = 1'b0;
  logic [N_IN-1:0] pin_in = '0;
  logic tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0;
  logic ext = 1'b0, smp = 1'b0, hz = 1'b0;
  logic [N_OUT-1:0] pin_out;
  logic pin_oe;
  logic [N_IN-1:0] core_in;
  logic tdo;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bscan_ring #(.N_OUT(N_OUT), .N_IN(N_IN), .CTL_IDX(CTL)) i_bscan_ring (
    .clk(clk), .rst(rst), .core_out(core_out), .core_oe(core_oe),
    .pin_in(pin_in), .tdi(tdi), .capture_dr(cap), .shift_dr(sh),
    .update_dr(upd), .mode_extest(ext), .mode_sample(smp), .mode_highz(hz),
    .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in), .tdo(tdo)
  );

  // chain index of a slot, from the layout stated in the requirements
  function automatic int idx_of(input int s);
    return (s < CTL) ? s : s + 1;
  endfunction

  logic [LEN-1:0]   m_sh, m_lat, m_old, m_cap;
  logic [N_OUT-1:0] m_pout;
  logic             m_poe;

  always @(posedge clk) begin
    if (rst) begin
      m_sh = '0; m_lat = '0; m_pout = '0; m_poe = 1'b0;
    end else begin
      for (int j = 0; j < N_OUT; j++) m_pout[j] = ext ? m_lat[idx_of(j)] : core_out[j];
      m_poe = hz ? 1'b0 : (ext ? m_lat[CTL] : core_oe);
      for (int j = 0; j < N_OUT; j++) m_cap[idx_of(j)] = core_out[j];
      for (int k = 0; k < N_IN; k++)  m_cap[idx_of(N_OUT+k)] = pin_in[k];
      m_cap[CTL] = core_oe;
      m_old = m_sh;
      if (cap)     m_sh = m_cap;
      else if (sh) m_sh = {tdi, m_sh[LEN-1:1]};
      if (upd && (ext || smp)) m_lat = m_old;
    end
  end

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [N_IN-1:0] exp_ci;
    for (int k = 0; k < N_IN; k++) exp_ci[k] = ext ? m_lat[idx_of(N_OUT+k)] : pin_in[k];
    chk("tdo", 64'(tdo), 64'(m_sh[0]));
    chk("pin_out", 64'(pin_out), 64'(m_pout));
    chk("pin_oe", 64'(pin_oe), 64'(m_poe));
    chk("core_in", 64'(core_in), 64'(exp_ci));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic rand_data();
    logic [63:0] r;
    r = {$urandom(), $urandom()}; core_out = r[N_OUT-1:0];
    r = {$urandom(), $urandom()}; pin_in = r[N_IN-1:0];
    core_oe = 1'($urandom() & 1);
  endtask

  task automatic strobes(input logic c, input logic s, input logic u, input logic d);
    cap = c; sh = s; upd = u; tdi = d;
  endtask

  task automatic modes(input logic e, input logic p, input logic h);
    ext = e; smp = p; hz = h;
  endtask

  task automatic shift_fill(input logic val, input int n);
    for (int n_i = 0; n_i < n; n_i++) begin
      strobes(1'b0, 1'b1, 1'b0, (val === 1'bx) ? 1'($urandom() & 1) : val);
      tick();
    end
    strobes(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rand_data();
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("pin_oe", 64'(pin_oe), 64'd0);
    chk("pin_out", 64'(pin_out), 64'd0);
    chk("tdo", 64'(tdo), 64'd0);
    rst = 1'b0;
    modes(1'b0, 1'b0, 1'b0);
    strobes(1'b0, 1'b0, 1'b0, 1'b0);
    tick();

    cur_tag = "R9";
    for (int n = 0; n < 6; n++) begin rand_data(); tick(); end

    cur_tag = "R10";
    for (int n = 0; n < 4; n++) begin rand_data(); tick(); end

    cur_tag = "R2";
    rand_data();
    strobes(1'b1, 1'b0, 1'b0, 1'b0); tick();
    rand_data();
    shift_fill(1'b0, LEN);

    cur_tag = "R11";
    rand_data();
    strobes(1'b1, 1'b1, 1'b0, 1'b1); tick();
    shift_fill(1'b1, 8);

    cur_tag = "R4";
    for (int n = 0; n < 5; n++) begin rand_data(); tick(); end

    cur_tag = "R3";
    shift_fill(1'bx, LEN);
    shift_fill(1'bx, LEN);

    cur_tag = "R7";
    modes(1'b1, 1'b0, 1'b0);
    shift_fill(1'b1, LEN);
    strobes(1'b0, 1'b0, 1'b1, 1'b0); tick();
    strobes(1'b0, 1'b0, 1'b0, 1'b0); tick(); tick();
    chk("pin_oe-on", 64'(pin_oe), 64'd1);
    cur_tag = "R6";
    chk("pin_out-ones", 64'(pin_out), 64'({N_OUT{1'b1}}));
    cur_tag = "R7";
    shift_fill(1'b0, LEN);
    strobes(1'b0, 1'b0, 1'b1, 1'b0); tick();
    strobes(1'b0, 1'b0, 1'b0, 1'b0); tick(); tick();
    chk("pin_oe-off", 64'(pin_oe), 64'd0);

    cur_tag = "R5";
    modes(1'b0, 1'b0, 1'b1);
    shift_fill(1'b1, LEN);
    strobes(1'b0, 1'b0, 1'b1, 1'b0); tick();
    strobes(1'b0, 1'b0, 1'b0, 1'b0);
    modes(1'b1, 1'b0, 1'b0); tick(); tick();
    chk("latch-unchanged", 64'(pin_out), 64'd0);

    cur_tag = "R8";
    modes(1'b1, 1'b0, 1'b1);
    shift_fill(1'b1, LEN);
    strobes(1'b0, 1'b0, 1'b1, 1'b0); tick();
    strobes(1'b0, 1'b0, 1'b0, 1'b0); tick(); tick();
    chk("pin_oe-forced", 64'(pin_oe), 64'd0);

    cur_tag = "R12";
    modes(1'b0, 1'b1, 1'b0);
    rand_data();
    strobes(1'b1, 1'b0, 1'b0, 1'b0); tick();
    shift_fill(1'bx, LEN);
    strobes(1'b0, 1'b0, 1'b1, 1'b0); rand_data(); tick();
    strobes(1'b0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 4; n++) begin rand_data(); tick(); end

    for (int n = 0; n < 3000; n++) begin
      int m;
      rand_data();
      strobes(1'(($urandom() % 8) == 0), 1'($urandom() & 1),
              1'(($urandom() % 8) == 0), 1'($urandom() & 1));
      m = int'($urandom() % 5);
      case (m)
        0: modes(1'b0, 1'b0, 1'b0);
        1: modes(1'b1, 1'b0, 1'b0);
        2: modes(1'b0, 1'b1, 1'b0);
        3: modes(1'b0, 1'b0, 1'b1);
        default: modes(1'b1, 1'b0, 1'b1);
      endcase
      if (hz) cur_tag = "R8";
      else if (ext) cur_tag = "R6";
      else if (smp) cur_tag = "R12";
      else cur_tag = "R9";
      tick();
    end

    summary();
    $finish;
  end

endmodule